// File: doc/BRIEF.md
# Card Access Strobe Sequencer

This block times a single access to a removable 16-bit card. Once a start request is accepted it runs three phases in a fixed order: address setup, strobe active, and hold. The number of bus clocks in each phase comes from bit fields of a 32-bit timing word. That word is captured when the request is accepted, along with a read/write flag and an I/O-versus-memory flag. During the strobe phase exactly one of four active-low strobe lines is driven low: memory read, memory write, I/O read or I/O write. At the end of the access the block pulses a completion flag.

A bus monitor counts every cycle of the access. An access that would reach the monitor limit is cut short and flagged as a timeout instead of completing.

Each card slot also has its own small control register. Two bits of that register drive the slot's active-high card reset pin and its active-low buffer enable. All of this is used by the host-side logic that decodes card windows, which sits outside this block.

Top module: `card_strobe_seq`

## Requirements
- R1: The setup count is timing-word bits 15:12, the strobe count is bits 11:7 and the hold count is bits 19:16, all in bus clocks. After acceptance the phases run setup, then strobe, then hold, each lasting its count in clocks. The first setup cycle is the cycle after the accepting clock edge.
- R2: A phase whose count is zero lasts exactly one clock. An all-zero timing word therefore gives a 3-cycle access with a 1-cycle strobe.
- R3: During the strobe phase, only the line chosen by the captured flags is low. The encoding is write=0/io=0 → mem_oe_n, write=1/io=0 → mem_we_n, write=0/io=1 → io_rd_n, write=1/io=1 → io_wr_n. The other three lines stay high, and all four are high outside the strobe phase.
- R4: `busy` is high from the first setup cycle through the last hold cycle. `done` is high for exactly that last hold cycle and for no other cycle.
- R5: A start request seen while `busy` is high is ignored, including one in the `done` cycle. The timing word and flags are sampled only at acceptance, so later changes have no effect on the running access.
- R6: An access of at most 59 cycles completes normally. Otherwise, in its 59th cycle the block raises `timeout` for one clock instead of `done`, and it is idle in the next cycle.
- R7: Control bit 7 of a slot's register drives that slot's `card_buf_en_n`; a value of 1 disables the buffers. The reset value of this bit is 1.
- R8: Control bit 6 drives that slot's `card_reset` active-high, with a reset value of 0. A write selects one slot through `ctrl_slot` and changes no other slot. The change is visible in the cycle after the write edge.
- R9: While reset is held low and after its release, before any start, all strobes are high and `busy`, `done` and `timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_start | input | 1 | Request to begin an access |
| acc_timing | input | 32 | Timing word holding setup, strobe and hold counts |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_io | input | 1 | 1 = I/O space, 0 = memory space |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse in the final hold cycle |
| timeout | output | 1 | One-cycle pulse when the bus monitor cuts an access short |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| ctrl_we | input | 1 | Write enable for a slot control register |
| ctrl_slot | input | 1 | Slot selected by a control write |
| ctrl_wdata | input | 8 | Control register write data |
| card_reset | output | 2 | Per-slot card reset, active high |
| card_buf_en_n | output | 2 | Per-slot card buffer enable, active low |

## Verification
Two functions can fall in the same cycle: normal completion and the bus-monitor cut-off. An access of exactly 59 cycles ends in the very cycle the monitor reaches its threshold, so the bench runs both that length and a 60-cycle access. It expects `done` with no `timeout` for the first, and `timeout` with no `done` at cycle 59 for the second. A second coincidence is a new start request, together with a control write, placed in the `done` cycle. The bench judges it by `busy` staying low in the following cycle while the control pins take the written value.

// File: rtl/card_seq_pkg.sv
// Shared types for the card access strobe sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package card_seq_pkg;

    // Access phase; PH_IDLE means no access in progress.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/seq_phase_ctrl.sv
// Phase controller: accepts a start request when idle, captures the
// timing fields and flags, then steps setup -> strobe -> hold.
// Each phase lasts max(count,1) clocks. A cut-off from the bus monitor
// ends the access early and raises timeout instead of done.
// Assumes: at_limit is only high while busy.
module seq_phase_ctrl
    import card_seq_pkg::*;
#(
    parameter int TIMING_W  = 32,
    parameter int SETUP_LSB = 12,
    parameter int SETUP_W   = 4,
    parameter int STRB_LSB  = 7,
    parameter int STRB_W    = 5,
    parameter int HOLD_LSB  = 16,
    parameter int HOLD_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [TIMING_W-1:0] timing,
    input  logic                write,
    input  logic                io,
    input  logic                at_limit,
    output phase_e              phase,
    output logic                lat_write,
    output logic                lat_io,
    output logic                busy,
    output logic                done,
    output logic                timeout
);

    localparam int MAX_SH = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
    localparam int CNT_W  = (STRB_W > MAX_SH) ? STRB_W : MAX_SH;

    // Clamp a zero count to one clock.
    function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] n);
        return (n == '0) ? CNT_W'(1) : n;
    endfunction

    logic [CNT_W-1:0] setup_n, strb_n, hold_n;
    logic [CNT_W-1:0] rem, strb_len, hold_len;
    logic             last_cycle;
    logic             timing_unused;

    // Field extraction with the one-clock floor.
    assign setup_n = floor_one(CNT_W'(timing[SETUP_LSB +: SETUP_W]));
    assign strb_n  = floor_one(CNT_W'(timing[STRB_LSB  +: STRB_W]));
    assign hold_n  = floor_one(CNT_W'(timing[HOLD_LSB  +: HOLD_W]));
    assign timing_unused = ^timing;

    // Status decoded from the phase register.
    assign last_cycle = (phase == PH_HOLD) && (rem == CNT_W'(1));
    assign busy       = (phase != PH_IDLE);
    assign done       = last_cycle;
    assign timeout    = at_limit && !last_cycle;

    // Phase stepping and per-phase countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            rem       <= '0;
            strb_len  <= '0;
            hold_len  <= '0;
            lat_write <= 1'b0;
            lat_io    <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_SETUP;
                        rem       <= setup_n;
                        strb_len  <= strb_n;
                        hold_len  <= hold_n;
                        lat_write <= write;
                        lat_io    <= io;
                    end
                end
                PH_SETUP: begin
                    if (timeout)                 phase <= PH_IDLE;
                    else if (rem == CNT_W'(1)) begin
                        phase <= PH_STROBE;
                        rem   <= strb_len;
                    end else                     rem   <= rem - 1'b1;
                end
                PH_STROBE: begin
                    if (timeout)                 phase <= PH_IDLE;
                    else if (rem == CNT_W'(1)) begin
                        phase <= PH_HOLD;
                        rem   <= hold_len;
                    end else                     rem   <= rem - 1'b1;
                end
                default: begin
                    if (done || timeout)         phase <= PH_IDLE;
                    else                         rem   <= rem - 1'b1;
                end
            endcase
        end
    end

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !timeout) |=> (busy && $stable(lat_write) && $stable(lat_io)));

    // R6
    timeout_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !busy);

endmodule

// File: rtl/seq_bus_monitor.sv
// Bus monitor: counts every cycle of an access, restarting at each
// accepted start, and flags the cycle at which the access must end.
// Assumes: accept is only high while the controller is idle.
module seq_bus_monitor #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic busy,
    output logic at_limit
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cyc;

    // Cycle counter: 1 in the first access cycle, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cyc <= '0;
        else if (accept)                      cyc <= CW'(1);
        else if (busy && cyc != CW'(LIMIT))   cyc <= cyc + 1'b1;
    end

    // Last permitted cycle of any access.
    assign at_limit = busy && (cyc == CW'(LIMIT - 1));

    // R6
    under_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cyc < CW'(LIMIT)));

endmodule

// File: rtl/seq_slot_ctrl.sv
// Per-slot control register: one bit drives the active-low card buffer
// enable, another the active-high card reset. Resets with buffers off
// and the card out of reset.
// Assumes: we is already qualified by slot selection.
module seq_slot_ctrl #(
    parameter int DATA_W  = 8,
    parameter int OE_BIT  = 7,
    parameter int RST_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              card_reset,
    output logic              buf_en_n
);

    logic wdata_unused;
    assign wdata_unused = ^wdata;

    // Control bits captured on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_en_n   <= 1'b1;
            card_reset <= 1'b0;
        end else if (we) begin
            buf_en_n   <= wdata[OE_BIT];
            card_reset <= wdata[RST_BIT];
        end
    end

    // R7
    buf_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (buf_en_n == $past(wdata[OE_BIT])));

    // R8
    rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(card_reset));

endmodule

// File: rtl/card_strobe_seq.sv
// Top level: phase controller, bus monitor, strobe decode and one
// control register per card slot.
// Assumes: a single sequencer is shared by all slots.
module card_strobe_seq
    import card_seq_pkg::*;
#(
    parameter int TIMING_W  = 32,
    parameter int SETUP_LSB = 12,
    parameter int SETUP_W   = 4,
    parameter int STRB_LSB  = 7,
    parameter int STRB_W    = 5,
    parameter int HOLD_LSB  = 16,
    parameter int HOLD_W    = 4,
    parameter int BMT_LIMIT = 60,
    parameter int NUM_SLOTS = 2,
    parameter int CTRL_W    = 8,
    parameter int OE_BIT    = 7,
    parameter int RST_BIT   = 6,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_start,
    input  logic [TIMING_W-1:0]  acc_timing,
    input  logic                 acc_write,
    input  logic                 acc_io,
    output logic                 busy,
    output logic                 done,
    output logic                 timeout,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic                 io_rd_n,
    output logic                 io_wr_n,
    input  logic                 ctrl_we,
    input  logic [SLOT_W-1:0]    ctrl_slot,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    output logic [NUM_SLOTS-1:0] card_reset,
    output logic [NUM_SLOTS-1:0] card_buf_en_n
);

    phase_e phase;
    logic   lat_write, lat_io, at_limit, accept, strobe_on;

    assign accept = acc_start && !busy;

    seq_phase_ctrl #(
        .TIMING_W (TIMING_W),
        .SETUP_LSB(SETUP_LSB), .SETUP_W(SETUP_W),
        .STRB_LSB (STRB_LSB),  .STRB_W (STRB_W),
        .HOLD_LSB (HOLD_LSB),  .HOLD_W (HOLD_W)
    ) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (acc_start),
        .timing   (acc_timing),
        .write    (acc_write),
        .io       (acc_io),
        .at_limit (at_limit),
        .phase    (phase),
        .lat_write(lat_write),
        .lat_io   (lat_io),
        .busy     (busy),
        .done     (done),
        .timeout  (timeout)
    );

    seq_bus_monitor #(.LIMIT(BMT_LIMIT)) i_bmon (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .busy    (busy),
        .at_limit(at_limit)
    );

    // Strobe select: one line per {space, direction}.
    assign strobe_on = (phase == PH_STROBE);
    assign mem_oe_n  = !(strobe_on && !lat_io && !lat_write);
    assign mem_we_n  = !(strobe_on && !lat_io &&  lat_write);
    assign io_rd_n   = !(strobe_on &&  lat_io && !lat_write);
    assign io_wr_n   = !(strobe_on &&  lat_io &&  lat_write);

    // One control register per slot.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        seq_slot_ctrl #(
            .DATA_W(CTRL_W), .OE_BIT(OE_BIT), .RST_BIT(RST_BIT)
        ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (ctrl_we && (ctrl_slot == SLOT_W'(g))),
            .wdata     (ctrl_wdata),
            .card_reset(card_reset[g]),
            .buf_en_n  (card_buf_en_n[g])
        );
    end

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_oe_n && mem_we_n && io_rd_n && io_wr_n));

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~mem_oe_n, ~mem_we_n, ~io_rd_n, ~io_wr_n}));

endmodule

// File: tb/test_card_strobe_seq.sv
`timescale 1ns/1ps
module test_card_strobe_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_start = 1'b0;
    logic [31:0] acc_timing = '0;
    logic        acc_write = 1'b0;
    logic        acc_io = 1'b0;
    logic        busy, done, timeout;
    logic        mem_oe_n, mem_we_n, io_rd_n, io_wr_n;
    logic        ctrl_we = 1'b0;
    logic [0:0]  ctrl_slot = '0;
    logic [7:0]  ctrl_wdata = '0;
    logic [1:0]  card_reset, card_buf_en_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    card_strobe_seq i_card_strobe_seq (
        .clk(clk), .rst_n(rst_n),
        .acc_start(acc_start), .acc_timing(acc_timing),
        .acc_write(acc_write), .acc_io(acc_io),
        .busy(busy), .done(done), .timeout(timeout),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .ctrl_we(ctrl_we), .ctrl_slot(ctrl_slot), .ctrl_wdata(ctrl_wdata),
        .card_reset(card_reset), .card_buf_en_n(card_buf_en_n)
    );

    // Columns: setup, strobe, hold, write, io, end cycle, timeout expected.
    localparam int VEC [8][7] = '{
        '{ 2,  3,  1, 0, 0,  6, 0},
        '{ 0,  0,  0, 0, 1,  3, 0},
        '{ 1,  5,  2, 1, 0,  8, 0},
        '{ 4, 10,  3, 1, 1, 17, 0},
        '{15, 29, 15, 0, 0, 59, 0},
        '{15, 30, 15, 1, 0, 59, 1},
        '{15, 31, 15, 0, 1, 59, 1},
        '{ 0, 31,  0, 1, 1, 33, 0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] make_word(input int s, input int l, input int h);
        logic [31:0] w = '0;
        w[15:12] = 4'(s);
        w[11:7]  = 5'(l);
        w[19:16] = 4'(h);
        return w;
    endfunction

    // One access; pa/pb are cycles in which a stray start and a slot-0
    // control write (reset on, buffers on) are driven.
    task automatic run_access(input int s, input int l, input int h, input int wr,
                              input int io, input int exp_end, input int exp_to,
                              input int pa, input int pb);
        int sel, first, cnt, wrong, done_c, done_n, to_c, busy_last, sp, lp, exp_cnt;
        logic [3:0] lines;
        sel = io * 2 + wr;
        first = 0; cnt = 0; wrong = 0; done_c = 0; done_n = 0; to_c = 0; busy_last = 0;
        @(negedge clk);
        acc_start = 1'b1; acc_timing = make_word(s, l, h);
        acc_write = wr[0]; acc_io = io[0];
        @(negedge clk);
        acc_start = 1'b0; acc_timing = '1; acc_write = ~acc_write; acc_io = ~acc_io;
        for (int c = 1; c <= 70; c++) begin
            lines = {io_wr_n, io_rd_n, mem_we_n, mem_oe_n};
            for (int k = 0; k < 4; k++) begin
                if (!lines[k]) begin
                    if (k == sel) begin
                        cnt++;
                        if (first == 0) first = c;
                    end else wrong++;
                end
            end
            if (done) begin done_n++; if (done_c == 0) done_c = c; end
            if (timeout && to_c == 0) to_c = c;
            if (busy) busy_last = c;
            acc_start  = (c == pa || c == pb);
            acc_timing = '0;
            ctrl_we    = (c == pa || c == pb);
            ctrl_slot  = '0;
            ctrl_wdata = 8'h40;
            @(negedge clk);
        end
        acc_start = 1'b0; ctrl_we = 1'b0;
        sp = (s == 0) ? 1 : s;
        lp = (l == 0) ? 1 : l;
        exp_cnt = ((sp + lp < exp_end) ? sp + lp : exp_end) - sp;
        check("R1", "first strobe cycle", first, sp + 1);
        check("R2", "strobe length", cnt, exp_cnt);
        check("R3", "wrong strobe lines low", wrong, 0);
        check("R4", "last busy cycle", busy_last, exp_end);
        if (exp_to != 0) begin
            check("R6", "timeout cycle", to_c, exp_end);
            check("R6", "done count on cut-off", done_n, 0);
        end else begin
            check("R4", "done cycle", done_c, exp_end);
            check("R4", "done count", done_n, 1);
            check("R6", "timeout on normal access", to_c, 0);
        end
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: state while reset is held
        check("R9", "busy in reset", int'(busy), 0);
        check("R9", "strobes in reset", int'({mem_oe_n, mem_we_n, io_rd_n, io_wr_n}), 15);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "strobes after reset", int'({mem_oe_n, mem_we_n, io_rd_n, io_wr_n}), 15);
        check("R9", "done/timeout/busy after reset", int'({done, timeout, busy}), 0);
        check("R7", "buffer enables at reset", int'(card_buf_en_n), 3);
        check("R8", "card resets at reset", int'(card_reset), 0);

        // R1 R2 R3 R4 R6: vector table
        for (int i = 0; i < 8; i++)
            run_access(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
                       VEC[i][5], VEC[i][6], 0, 0);

        // R5: stray starts mid-access and in the done cycle, with control writes
        run_access(2, 3, 1, 0, 0, 6, 0, 2, 6);
        check("R5", "busy after ignored starts", int'(busy), 0);
        check("R8", "slot0 reset after same-cycle write", int'(card_reset[0]), 1);
        check("R7", "slot0 buffers after same-cycle write", int'(card_buf_en_n[0]), 0);
        check("R8", "slot1 untouched", int'({card_reset[1], card_buf_en_n[1]}), 1);

        // R7 R8: direct control writes to slot 1
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_slot = 1'b1; ctrl_wdata = 8'h80;
        @(negedge clk);
        ctrl_we = 1'b0;
        check("R7", "slot1 buffers disabled", int'(card_buf_en_n[1]), 1);
        check("R8", "slot1 reset low", int'(card_reset[1]), 0);
        ctrl_we = 1'b1; ctrl_slot = 1'b1; ctrl_wdata = 8'h3F;
        @(negedge clk);
        ctrl_we = 1'b0;
        check("R7", "slot1 buffers enabled", int'(card_buf_en_n[1]), 0);
        check("R8", "slot1 reset ignores other bits", int'(card_reset[1]), 0);
        check("R8", "slot0 kept", int'({card_reset[0], card_buf_en_n[0]}), 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule